// File: doc/BRIEF.md
# Bitwise Ternary Logic Evaluator

This unit evaluates any Boolean function of three inputs across three wide operands in one pass. An 8-bit function code serves as a truth table. For every bit position, the bits of the three operands at that position form a 3-bit selector, and the selector picks one bit of the function code as the result bit. No bit position affects any other, so there are no carries. The function code is read most-significant-bit first. Selector value k therefore picks code bit `7-k` in ordinary little-endian numbering. The first operand supplies the top selector bit and the third operand supplies the bottom one.

Operands are presented together with a valid strobe. One clock later the result appears in a register, and an output valid flag rises with it. The result register loads only on cycles where the strobe is high, and it holds its value on every other cycle. The operand width is a parameter, so one design serves both a 64-bit scalar datapath and a 128-bit vector datapath.

The output valid flag comes from a two-state machine. `ST_EMPTY` means no new result was loaded on the last edge. `ST_FRESH` means a result was loaded on the last edge. The machine moves to `ST_FRESH` on any edge where the strobe is high, from either state. It moves to `ST_EMPTY` on any edge where the strobe is low, from either state. Reset places it in `ST_EMPTY`.

Top module: `ternlog_eval`

## Requirements
- R1: For every bit position i, the result bit equals `fn[7 - {op_a[i], op_b[i], op_c[i]}]`, where `fn` is numbered little-endian and `op_a[i]` is the most significant bit of the selector.
- R2: While `rst` is high at a clock edge, `out_valid` becomes 0 and `result` becomes all zeros.
- R3: `out_valid` equals the value `in_valid` had at the previous clock edge.
- R4: On an edge where `in_valid` is low, `result` keeps its previous value, whatever the operands and function code are.
- R5: Operands and a function code sampled on an edge where `in_valid` is high determine `result` from that edge onward. This is a latency of exactly one clock.
- R6: Function code 0x00 gives all zeros and 0xFF gives all ones, for any operands.
- R7: Function codes 0x0F, 0x33 and 0x55 pass through `op_a`, `op_b` and `op_c` respectively. Codes 0xF0, 0xCC and 0xAA give the bitwise inverses of those operands.
- R8: Function code 0x69 gives the three-way XOR, 0x96 gives its complement, 0x17 gives the majority function, 0xE8 gives the minority function, and 0x01 gives the three-way AND.
- R9: Every bit position is evaluated independently. A function code applied to operands whose bits differ from one position to the next gives, at each position, the bit that R1 selects for that position alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe; operands and code are taken on this edge |
| op_a | input | W | First operand, most significant selector bit |
| op_b | input | W | Second operand, middle selector bit |
| op_c | input | W | Third operand, least significant selector bit |
| fn | input | 8 | Truth-table function code |
| out_valid | output | 1 | High for one cycle after each strobed edge |
| result | output | W | Registered evaluation result |

## Verification
A stimulus strobed on one rising edge has its result and valid flag due after that edge. The bench drives each stimulus on a falling edge and samples the outputs on the next falling edge, half a cycle after the loading edge. For the hold behaviour, the bench changes the operands with the strobe low and checks on the following falling edge that `result` still holds the earlier value and `out_valid` has dropped. The reset state is sampled on a falling edge while reset is still asserted.

// File: rtl/ternlog_pkg.sv
package ternlog_pkg;
    localparam int FN_W  = 8;
    localparam int SEL_W = $clog2(FN_W);

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FRESH = 1'b1
    } vstate_t;
endpackage

// File: rtl/ternlog_bit.sv
module ternlog_bit
    import ternlog_pkg::*;
(
    input  logic            a,
    input  logic            b,
    input  logic            c,
    input  logic [FN_W-1:0] fn,
    output logic            y
);
    logic [SEL_W-1:0] sel;

    always_comb begin
        sel = {a, b, c};
        // MSB-first truth table: selector k picks code bit (FN_W-1-k)
        y = fn[SEL_W'(FN_W - 1) - sel];
    end
endmodule

// File: rtl/ternlog_array.sv
module ternlog_array
    import ternlog_pkg::*;
#(
    parameter int W = 128
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [W-1:0]    c,
    input  logic [FN_W-1:0] fn,
    output logic [W-1:0]    y
);
    for (genvar i = 0; i < W; i++) begin : g_lane
        ternlog_bit u_bit (
            .a  (a[i]),
            .b  (b[i]),
            .c  (c[i]),
            .fn (fn),
            .y  (y[i])
        );
    end
endmodule

// File: rtl/ternlog_vld_fsm.sv
module ternlog_vld_fsm
    import ternlog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic out_valid
);
    vstate_t state_q, state_d;

    always_comb begin
        state_d = in_valid ? ST_FRESH : ST_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY: out_valid = 1'b0;
            ST_FRESH: out_valid = 1'b1;
            default:  out_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/ternlog_eval.sv
module ternlog_eval
    import ternlog_pkg::*;
#(
    parameter int W = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [W-1:0]    op_a,
    input  logic [W-1:0]    op_b,
    input  logic [W-1:0]    op_c,
    input  logic [FN_W-1:0] fn,
    output logic            out_valid,
    output logic [W-1:0]    result
);
    logic [W-1:0] eval_d;

    ternlog_array #(.W(W)) u_array (
        .a  (op_a),
        .b  (op_b),
        .c  (op_c),
        .fn (fn),
        .y  (eval_d)
    );

    ternlog_vld_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_valid (out_valid)
    );

    always_ff @(posedge clk) begin
        if (rst)           result <= '0;
        else if (in_valid) result <= eval_d;
    end
endmodule

// File: rtl/ternlog_chk.sv
module ternlog_chk #(
    parameter int W = 128
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] op_c,
    input logic [7:0]   fn,
    input logic         out_valid,
    input logic [W-1:0] result
);
    a_r2_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    a_r3_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r3_valid_drop: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    a_r6_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fn == 8'h00) |=> result == '0);

    a_r6_ones: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fn == 8'hFF) |=> result == '1);

    a_r7_pass_a: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fn == 8'h0F) |=> result == $past(op_a));

    a_r7_pass_b: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fn == 8'h33) |=> result == $past(op_b));

    a_r7_pass_c: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fn == 8'h55) |=> result == $past(op_c));

    a_r8_xor3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fn == 8'h69) |=> result == ($past(op_a) ^ $past(op_b) ^ $past(op_c)));
endmodule

bind ternlog_eval ternlog_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_c      (op_c),
    .fn        (fn),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_ternlog_eval.sv
module sim_ternlog_eval;
    localparam int CLK_PERIOD = 10;
    localparam int W = 128;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0, op_c = '0;
    logic [7:0]   fn = 8'h00;
    logic         out_valid;
    logic [W-1:0] result;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ternlog_eval #(.W(W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .fn(fn),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [W-1:0] ref_eval(logic [W-1:0] a, logic [W-1:0] b,
                                              logic [W-1:0] c, logic [7:0] f);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            int k;
            k = 4 * int'(a[i]) + 2 * int'(b[i]) + int'(c[i]);
            r[i] = f[7 - k];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] rnd_word();
        logic [W-1:0] v;
        for (int j = 0; j < W / 32; j++) v[j*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] c, input logic [7:0] f,
                         input logic [W-1:0] exp, input string req);
        op_a = a; op_b = b; op_c = c; fn = f; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(result === exp, req, result, exp);
        check(out_valid === 1'b1, {req, " valid (R3, R5)"}, {{(W-1){1'b0}}, out_valid}, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] a, b, c, held;
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: reset state
        check(result === '0, "R2 result", result, '0);
        check(out_valid === 1'b0, "R2 valid", {{(W-1){1'b0}}, out_valid}, 0);
        rst = 1'b0;

        a = rnd_word(); b = rnd_word(); c = rnd_word();
        // R6: constants
        apply(a, b, c, 8'h00, '0, "R6 zero");
        apply(a, b, c, 8'hFF, '1, "R6 ones");
        // R7: pass and invert
        apply(a, b, c, 8'h0F, a, "R7 pass a");
        apply(a, b, c, 8'h33, b, "R7 pass b");
        apply(a, b, c, 8'h55, c, "R7 pass c");
        apply(a, b, c, 8'hF0, ~a, "R7 not a");
        apply(a, b, c, 8'hCC, ~b, "R7 not b");
        apply(a, b, c, 8'hAA, ~c, "R7 not c");
        // R8: named functions
        apply(a, b, c, 8'h69, a ^ b ^ c, "R8 xor3");
        apply(a, b, c, 8'h96, ~(a ^ b ^ c), "R8 xnor3");
        apply(a, b, c, 8'h17, (a & b) | (a & c) | (b & c), "R8 majority");
        apply(a, b, c, 8'hE8, ~((a & b) | (a & c) | (b & c)), "R8 minority");
        apply(a, b, c, 8'h01, a & b & c, "R8 and3");

        // R9: every selector value present in neighbouring lanes
        begin
            logic [W-1:0] pa, pb, pc;
            for (int i = 0; i < W; i++) begin
                pa[i] = i[2]; pb[i] = i[1]; pc[i] = i[0];
            end
            apply(pa, pb, pc, 8'hB4, ref_eval(pa, pb, pc, 8'hB4), "R9 lane pattern");
            // R1: single-minterm codes on the lane pattern
            for (int k = 0; k < 8; k++) begin
                logic [7:0] f;
                f = 8'h01 << k;
                apply(pa, pb, pc, f, ref_eval(pa, pb, pc, f), "R1 minterm");
            end
        end

        // R4: hold with strobe low while inputs change
        held = result;
        in_valid = 1'b0;
        op_a = ~op_a; fn = 8'h5A;
        @(posedge clk);
        @(negedge clk);
        check(result === held, "R4 hold", result, held);
        check(out_valid === 1'b0, "R3 valid drop", {{(W-1){1'b0}}, out_valid}, 0);
        op_b = rnd_word();
        @(posedge clk);
        @(negedge clk);
        check(result === held, "R4 hold second cycle", result, held);

        // R1, R5: random codes against the bit-loop model
        for (int n = 0; n < 200; n++) begin
            logic [7:0] f;
            a = rnd_word(); b = rnd_word(); c = rnd_word();
            f = 8'($urandom);
            apply(a, b, c, f, ref_eval(a, b, c, f), "R1 random");
            if (n % 17 == 0) begin
                held = result;
                in_valid = 1'b0;
                op_c = rnd_word();
                @(posedge clk);
                @(negedge clk);
                check(result === held, "R4 random hold", result, held);
            end
        end

        // R2: reset in mid-stream clears loaded result
        rst = 1'b1;
        in_valid = 1'b1; fn = 8'hFF;
        @(posedge clk);
        @(negedge clk);
        check(result === '0, "R2 mid reset", result, '0);
        check(out_valid === 1'b0, "R2 mid reset valid", {{(W-1){1'b0}}, out_valid}, 0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule